// File: doc/BRIEF.md
# Link BIST Pattern Generator

This block sits in front of a serial transmitter and, on request, replaces the normal character stream with a self-test pattern. While the test mode is on, it emits one pseudo-random character per accepted transfer from a 9-bit maximal-length shift register, so the pattern repeats every 511 characters. When the test mode is switched off, the transmitter sees the normal data path again. The far end can compare the received pattern against its own copy of the sequence to check the link.

While the test runs, the block holds off reads from the transmit FIFO. It also takes over the FIFO-empty flag: instead of reporting FIFO state, that flag pulses for one clock after each complete 511-character sequence, so a controller can count finished sequences. The generator only advances when the downstream stage signals ready. Each new test run starts from the same fixed seed. A sequence that is cut short by leaving test mode is dropped and produces no pulse.

Top module: `link_bist_gen`

## Requirements
- R1: While `rst_n` is low, the block is in normal mode: `tx_data_o`, `tx_valid_o` and `tx_empty_o` follow `norm_data_i`, `norm_valid_i` and `fifo_empty_i`, and `fifo_rd_hold_o` is low.
- R2: If `bist_en_i` is high at a clock edge while in normal mode, test mode starts at that edge. From the next cycle `tx_data_o` equals the seed 10'h1FF: the 9-bit seed 9'h1FF, zero-extended.
- R3: Each test character is the 9-bit shift-register state in `tx_data_o[8:0]`, with `tx_data_o[9]` at zero. After an accepted character (ready and `bist_en_i` both high at the edge), the next state is `{s[7:0], s[8] ^ s[4]}`, which is the polynomial x^9+x^5+1.
- R4: The 511 characters of one sequence are all distinct and nonzero. The character after the 511th accepted one equals the seed again.
- R5: In test mode, a clock edge with `tx_ready_i` low leaves `tx_data_o` unchanged.
- R6: In test mode, `tx_empty_o` ignores `fifo_empty_i`. It is high for exactly one cycle: the cycle right after the edge that accepts the 511th character of a sequence. It is low in all other test-mode cycles.
- R7: In test mode, `fifo_rd_hold_o` and `tx_valid_o` are high in every cycle.
- R8: Leaving test mode takes effect at the first edge where `bist_en_i` is low and `tx_ready_i` is high. Until that edge the current test character is held. From the next cycle the normal path is back and `fifo_rd_hold_o` is low.
- R9: A partial sequence abandoned by leaving test mode gives no pulse on `tx_empty_o`, even if 510 characters were sent. Re-entering test mode restarts from the seed.
- R10: In normal mode after reset, the outputs pass through the normal data, valid and empty inputs in the same cycle, and `fifo_rd_hold_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bist_en_i | input | 1 | Requests test mode when high |
| tx_ready_i | input | 1 | Downstream accepts the current character |
| norm_data_i | input | DATA_W (10) | Normal-path character |
| norm_valid_i | input | 1 | Normal-path character valid |
| fifo_empty_i | input | 1 | Normal FIFO-empty flag |
| tx_data_o | output | DATA_W (10) | Character to the transmitter |
| tx_valid_o | output | 1 | Character valid |
| fifo_rd_hold_o | output | 1 | Suspends transmit FIFO reads while high |
| tx_empty_o | output | 1 | FIFO-empty flag, or the sequence-end pulse in test mode |

## Verification
The assertions check the cycle-local rules on every cycle:
- the shift step between accepted characters;
- the held character on stalls;
- a nonzero pattern with valid and hold asserted;
- entry landing on the seed;
- exit after a ready edge;
- sequence-end pulses never lasting two cycles.

Only the bench's scenarios can show the properties that span a whole sequence. These are:
- the 511-character period and the distinctness of its characters;
- the pulse landing after exactly the 511th accepted character under an irregular ready pattern;
- the lack of a pulse after an abandoned 510-character run.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_BIST   = 1'b1
  } bist_mode_e;
endpackage

// File: rtl/bist_rst_sync.sv
module bist_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int          W    = 9,
  parameter int          TAP  = 5,
  parameter logic [W-1:0] SEED = 9'h1FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] step;
  logic [W-1:0] state_d;
  logic         en;

  // Fibonacci feedback from the top stage and the tap stage
  assign step[0] = state_q[W-1] ^ state_q[TAP-1];
  for (genvar i = 1; i < W; i++) begin : g_shift
    assign step[i] = state_q[i-1];
  end

  assign en = load_i | adv_i;

  always_comb begin
    state_d = state_q;
    if (load_i)     state_d = SEED;
    else if (adv_i) state_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  state_q <= SEED;
    else if (en) state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bist_seq_counter.sv
module bist_seq_counter #(
  parameter int PERIOD = 511
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic wrap_pulse_o
);
  localparam int              CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             pulse_q;
  logic             pulse_d;
  logic             at_last;
  logic             cnt_en;

  assign at_last = (cnt_q == LAST);
  assign cnt_en  = clr_i | adv_i;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d   = at_last ? '0 : cnt_q + 1'b1;
      pulse_d = at_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign wrap_pulse_o = pulse_q;
endmodule

// File: rtl/bist_out_mux.sv
module bist_out_mux
  import link_bist_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int W      = 9
) (
  input  bist_mode_e        mode_i,
  input  logic [W-1:0]      pattern_i,
  input  logic              prog_i,
  input  logic [DATA_W-1:0] norm_data_i,
  input  logic              norm_valid_i,
  input  logic              fifo_empty_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_empty_o
);
  always_comb begin
    if (mode_i == MODE_BIST) begin
      tx_data_o  = DATA_W'(pattern_i);
      tx_valid_o = 1'b1;
      tx_empty_o = prog_i;
    end else begin
      tx_data_o  = norm_data_i;
      tx_valid_o = norm_valid_i;
      tx_empty_o = fifo_empty_i;
    end
  end
endmodule

// File: rtl/link_bist_gen.sv
module link_bist_gen
  import link_bist_pkg::*;
#(
  parameter int           DATA_W     = 10,
  parameter int           W          = 9,
  parameter int           TAP        = 5,
  parameter logic [W-1:0] SEED       = 9'h1FF,
  parameter int           SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bist_en_i,
  input  logic              tx_ready_i,
  input  logic [DATA_W-1:0] norm_data_i,
  input  logic              norm_valid_i,
  input  logic              fifo_empty_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              fifo_rd_hold_o,
  output logic              tx_empty_o
);
  localparam int PERIOD = (1 << W) - 1;

  logic       core_rst_n;
  bist_mode_e mode_q;
  bist_mode_e mode_d;
  logic       enter;
  logic       adv;
  logic [W-1:0] pattern;
  logic       prog;

  bist_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  assign enter = (mode_q == MODE_NORMAL) && bist_en_i;
  assign adv   = (mode_q == MODE_BIST) && bist_en_i && tx_ready_i;

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      MODE_NORMAL: if (bist_en_i)                mode_d = MODE_BIST;
      MODE_BIST:   if (!bist_en_i && tx_ready_i) mode_d = MODE_NORMAL;
      default:                                   mode_d = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_NORMAL;
    else if (!core_rst_n) mode_q <= MODE_NORMAL;
    else                  mode_q <= mode_d;
  end

  bist_lfsr #(.W(W), .TAP(TAP), .SEED(SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .load_i  (enter),
    .adv_i   (adv),
    .state_o (pattern)
  );

  bist_seq_counter #(.PERIOD(PERIOD)) u_seq_cnt (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .clr_i        (enter),
    .adv_i        (adv),
    .wrap_pulse_o (prog)
  );

  bist_out_mux #(.DATA_W(DATA_W), .W(W)) u_out_mux (
    .mode_i       (mode_q),
    .pattern_i    (pattern),
    .prog_i       (prog),
    .norm_data_i  (norm_data_i),
    .norm_valid_i (norm_valid_i),
    .fifo_empty_i (fifo_empty_i),
    .tx_data_o    (tx_data_o),
    .tx_valid_o   (tx_valid_o),
    .tx_empty_o   (tx_empty_o)
  );

  assign fifo_rd_hold_o = (mode_q == MODE_BIST);
endmodule

// File: rtl/link_bist_gen_chk.sv
module link_bist_gen_chk #(
  parameter int           DATA_W = 10,
  parameter int           W      = 9,
  parameter int           TAP    = 5,
  parameter logic [W-1:0] SEED   = 9'h1FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic              bist_en_i,
  input logic              tx_ready_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              fifo_rd_hold_o,
  input logic              tx_empty_o
);
  function automatic logic [DATA_W-1:0] nxt(input logic [DATA_W-1:0] c);
    logic [W-1:0] s;
    s = c[W-1:0];
    return DATA_W'({s[W-2:0], s[W-1] ^ s[TAP-1]});
  endfunction

  assert_entry_seed_R2: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (!fifo_rd_hold_o && bist_en_i) |=> (fifo_rd_hold_o && tx_data_o == DATA_W'(SEED)));

  assert_lfsr_step_R3: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (fifo_rd_hold_o && $past(fifo_rd_hold_o) && $past(tx_ready_i) && $past(bist_en_i))
      |-> (tx_data_o == nxt($past(tx_data_o))));

  assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    fifo_rd_hold_o |-> (tx_data_o[W-1:0] != '0));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (fifo_rd_hold_o && $past(fifo_rd_hold_o) && !$past(tx_ready_i)) |-> $stable(tx_data_o));

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (fifo_rd_hold_o && tx_empty_o) |=> !(fifo_rd_hold_o && tx_empty_o));

  assert_valid_in_bist_R7: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    fifo_rd_hold_o |-> tx_valid_o);

  assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (fifo_rd_hold_o && !bist_en_i && tx_ready_i) |=> !fifo_rd_hold_o);

  assert_stay_R8: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (fifo_rd_hold_o && !tx_ready_i) |=> fifo_rd_hold_o);
endmodule

bind link_bist_gen link_bist_gen_chk #(
  .DATA_W(DATA_W), .W(W), .TAP(TAP), .SEED(SEED)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_rst_n     (core_rst_n),
  .bist_en_i      (bist_en_i),
  .tx_ready_i     (tx_ready_i),
  .tx_data_o      (tx_data_o),
  .tx_valid_o     (tx_valid_o),
  .fifo_rd_hold_o (fifo_rd_hold_o),
  .tx_empty_o     (tx_empty_o)
);

// File: tb/link_bist_gen_tb_top.sv
module link_bist_gen_tb_top;
  localparam logic [8:0] SEED_EXP = 9'h1FF;

  logic       clk;
  logic       rst_n;
  logic       bist_en_i;
  logic       tx_ready_i;
  logic [9:0] norm_data_i;
  logic       norm_valid_i;
  logic       fifo_empty_i;
  logic [9:0] tx_data_o;
  logic       tx_valid_o;
  logic       fifo_rd_hold_o;
  logic       tx_empty_o;

  int checks;
  int fails;
  bit done;

  logic [8:0] exp_s;
  int         exp_cnt;
  bit         exp_pulse;
  int         pulses_seen;
  bit         seen [512];
  bit         track_seen;

  link_bist_gen dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .bist_en_i      (bist_en_i),
    .tx_ready_i     (tx_ready_i),
    .norm_data_i    (norm_data_i),
    .norm_valid_i   (norm_valid_i),
    .fifo_empty_i   (fifo_empty_i),
    .tx_data_o      (tx_data_o),
    .tx_valid_o     (tx_valid_o),
    .fifo_rd_hold_o (fifo_rd_hold_o),
    .tx_empty_o     (tx_empty_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [8:0] poly_step(input logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic chk_normal(input string req);
    chk(tx_data_o == norm_data_i, req, tx_data_o, norm_data_i);
    chk(tx_valid_o == norm_valid_i, req, tx_valid_o, norm_valid_i);
    chk(tx_empty_o == fifo_empty_i, req, tx_empty_o, fifo_empty_i);
    chk(fifo_rd_hold_o == 1'b0, req, fifo_rd_hold_o, 0);
  endtask

  // One test-mode cycle with bist_en_i high; model advances on ready
  task automatic bist_cycle(input logic rdy);
    @(negedge clk);
    tx_ready_i = rdy;
    #1;
    chk(tx_data_o == {1'b0, exp_s}, "R3 pattern char", tx_data_o, {1'b0, exp_s});
    chk(fifo_rd_hold_o && tx_valid_o, "R7 hold and valid", {fifo_rd_hold_o, tx_valid_o}, 2'b11);
    chk(tx_empty_o == exp_pulse, "R6 progress pulse", tx_empty_o, exp_pulse);
    if (tx_empty_o) pulses_seen++;
    if (track_seen && rdy) begin
      chk(!seen[tx_data_o[8:0]] && tx_data_o[8:0] != 9'h0, "R4 distinct nonzero", tx_data_o, 0);
      seen[tx_data_o[8:0]] = 1'b1;
    end
    exp_pulse = rdy && (exp_cnt == 510);
    if (rdy) begin
      if (exp_cnt == 510) begin
        exp_cnt = 0;
        track_seen = 1'b0;
      end else begin
        exp_cnt++;
      end
      exp_s = poly_step(exp_s);
      if (exp_cnt == 0)
        chk(exp_s == SEED_EXP, "R4 period returns to seed", exp_s, SEED_EXP);
    end
  endtask

  task automatic enter_bist();
    @(negedge clk);
    bist_en_i  = 1'b1;
    tx_ready_i = 1'b1;
    #1;
    chk(fifo_rd_hold_o == 1'b0, "R2 entry needs an edge", fifo_rd_hold_o, 0);
    exp_s     = SEED_EXP;
    exp_cnt   = 0;
    exp_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0; pulses_seen = 0; track_seen = 1'b0;
    rst_n = 1'b0; bist_en_i = 1'b0; tx_ready_i = 1'b0;
    norm_data_i = '0; norm_valid_i = 1'b0; fifo_empty_i = 1'b1;
    for (int i = 0; i < 512; i++) seen[i] = 1'b0;

    // R1: reset state and pass-through during reset
    repeat (3) @(negedge clk);
    #1;
    chk_normal("R1 reset state");
    @(negedge clk);
    norm_data_i = 10'h2AB; norm_valid_i = 1'b1; fifo_empty_i = 1'b0; bist_en_i = 1'b1;
    #1;
    chk_normal("R1 reset pass-through");
    @(negedge clk);
    #1;
    chk_normal("R1 bist ignored in reset");
    @(negedge clk);
    bist_en_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: normal-mode sweep
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      norm_data_i  = 10'((i * 67 + 5) % 1024);
      norm_valid_i = i[0];
      fifo_empty_i = i[1];
      tx_ready_i   = i[2];
      #1;
      chk_normal("R10 normal pass-through");
    end

    // R2..R7: two full sequences with an irregular ready pattern
    fifo_empty_i = 1'b1;
    track_seen = 1'b1;
    enter_bist();
    chk(1'b1, "R2 entry", 0, 0);
    for (int k = 0; k < 1400; k++) bist_cycle(1'((k % 4) != 3) & 1'((k % 7) != 5));
    chk(pulses_seen >= 1, "R6 pulse count", pulses_seen, 1);
    for (int k = 0; k < 400; k++) bist_cycle(1'b1);
    chk(pulses_seen == 2, "R6 pulse count", pulses_seen, 2);

    // R8: exit held while ready low, then taken on a ready edge
    @(negedge clk);
    bist_en_i = 1'b0; tx_ready_i = 1'b0; fifo_empty_i = 1'b0;
    #1;
    chk(tx_data_o == {1'b0, exp_s}, "R8 still bist", tx_data_o, {1'b0, exp_s});
    @(negedge clk);
    #1;
    chk(fifo_rd_hold_o == 1'b1, "R8 stays while not ready", fifo_rd_hold_o, 1);
    chk(tx_data_o == {1'b0, exp_s}, "R8 char held", tx_data_o, {1'b0, exp_s});
    @(negedge clk);
    tx_ready_i = 1'b1;
    #1;
    chk(fifo_rd_hold_o == 1'b1, "R8 exit needs an edge", fifo_rd_hold_o, 1);
    @(negedge clk);
    norm_data_i = 10'h155; norm_valid_i = 1'b0;
    #1;
    chk_normal("R8 normal after exit");

    // R9: abandon after 510 characters; no pulse, restart from seed
    enter_bist();
    for (int k = 0; k < 510; k++) bist_cycle(1'b1);
    @(negedge clk);
    bist_en_i = 1'b0; tx_ready_i = 1'b1; fifo_empty_i = 1'b0;
    #1;
    chk(tx_empty_o == 1'b0, "R9 no pulse before exit", tx_empty_o, 0);
    @(negedge clk);
    #1;
    chk_normal("R9 no pulse after abandon");
    @(negedge clk);
    fifo_empty_i = 1'b1;
    #1;
    chk_normal("R9 normal empty follows input");
    enter_bist();
    bist_cycle(1'b0);
    chk(tx_data_o == {1'b0, SEED_EXP}, "R9 restart from seed", tx_data_o, {1'b0, SEED_EXP});
    for (int k = 0; k < 20; k++) bist_cycle(1'b1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule